// File: doc/BRIEF.md
# Integer ALU with Signed Compare and Status Flags

This block is the arithmetic and logic unit of a 32-bit integer pipeline. A 4-bit operation code selects the operation applied to two operands: add, subtract, bitwise AND, OR and NOR, or a signed less-than test. Each cycle the block produces a result word and two flags. The zero flag drives the decision for equal and not-equal branches, which subtract the two registers and test for a zero difference. The overflow flag reports signed overflow on add and subtract, so the pipeline can raise an exception.

Subtraction uses the same adder as addition. Operand B is inverted and the carry-in is set to one. The less-than test takes the sign of that difference and XORs it with the overflow flag, so the answer stays correct even when the difference itself overflows. An unsigned-mode input stops the overflow flag from being raised, for the non-trapping forms of add and subtract. Immediate operands are sign-extended to 32 bits before they reach the block. The outputs are registered, and they are valid one clock after the inputs are sampled.

Top module: `alu_core`

## Requirements
- R1: Code 4'b0010 gives result = (A + B) mod 2^32.
- R2: Code 4'b0110 gives result = (A - B) mod 2^32.
- R3: Code 4'b0000 gives A AND B, code 4'b0001 gives A OR B, and code 4'b1100 gives NOT (A OR B), each applied bit by bit.
- R4: Code 4'b0111 gives result = 1 when A < B as two's-complement signed values and 0 otherwise, with bits 31..1 always zero. This holds even when A - B overflows.
- R5: The zero flag is 1 exactly when the registered result is all zeros.
- R6: For add, the overflow flag is 1 when A and B have the same sign and the sum has the other sign. For subtract, the same test is applied to A and the inverted B, which means the true signed difference is out of range.
- R7: The overflow flag is 0 for AND, OR, NOR and less-than.
- R8: When the unsigned-mode input is 1, the overflow flag is 0 for every code. The result is not affected.
- R9: Any code not listed above gives result 0, zero flag 1 and overflow flag 0.
- R10: Inputs are sampled on a rising clock edge, and the outputs show the answer after that same edge. Active-low reset sets result to 0, zero to 1 and overflow to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Operation select |
| unsigned_mode | input | 1 | 1 = keep the overflow flag at 0 |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (already sign-extended if it is an immediate) |
| result | output | 32 | Registered result |
| zero_flag | output | 1 | Registered result is all zeros |
| ovf_flag | output | 1 | Registered signed overflow |

## Verification
The bench aims at the less-than cases where A - B overflows, such as the most negative value compared with 1, or the most positive value compared with -1. A design that read only the sign bit of the difference would return the inverted answer in these cases. It also drives add and subtract across the sign boundary in both directions, including 0x80000000 + 0x80000000. That sum wraps to zero with overflow set, so one vector tests the zero flag and the overflow flag together. A design that inverted B without setting carry-in would be off by one on every difference. A design that used the overflow rule for add on subtract would miss 0x80000000 - 1. Unused codes and unsigned mode are checked to show that no stale or forced flag leaks through.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int DATA_W = 32;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        LOG_AND = 2'd0,
        LOG_OR  = 2'd1,
        LOG_NOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              zero;
        logic              ovf;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         less
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W-1:0] cin_vec;

    always_comb begin
        b_eff   = b ^ {W{invert_b}};
        cin_vec = {{(W-1){1'b0}}, invert_b};
        sum     = a + b_eff + cin_vec;
        ovf     = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        less    = sum[MSB] ^ ovf;
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    input  alu_pkg::logic_sel_e   sel,
    output logic [W-1:0]          y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (sel)
                alu_pkg::LOG_AND: y[i] = a[i] & b[i];
                alu_pkg::LOG_OR:  y[i] = a[i] | b[i];
                alu_pkg::LOG_NOR: y[i] = ~(a[i] | b[i]);
                default:          y[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_code,
    input  logic              unsigned_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              ovf_flag
);
    localparam alu_state_t RESET_STATE = '{result: '0, zero: 1'b1, ovf: 1'b0};

    alu_state_t state_d, state_q;

    logic              invert_d;
    logic              arith_d;
    logic_sel_e        lsel_d;
    logic [DATA_W-1:0] sum_w;
    logic              ovf_w;
    logic              less_w;
    logic [DATA_W-1:0] logic_w;

    // decode: invert B for subtract and compare
    always_comb begin
        invert_d = 1'b0;
        arith_d  = 1'b0;
        lsel_d   = LOG_AND;
        case (op_code)
            OP_ADD: arith_d = 1'b1;
            OP_SUB: begin arith_d = 1'b1; invert_d = 1'b1; end
            OP_SLT: invert_d = 1'b1;
            OP_OR:  lsel_d = LOG_OR;
            OP_NOR: lsel_d = LOG_NOR;
            default: ;
        endcase
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .invert_b (invert_d),
        .sum      (sum_w),
        .ovf      (ovf_w),
        .less     (less_w)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (lsel_d),
        .y   (logic_w)
    );

    always_comb begin
        state_d = '0;
        case (op_code)
            OP_ADD, OP_SUB:         state_d.result = sum_w;
            OP_SLT:                 state_d.result = {{(DATA_W-1){1'b0}}, less_w};
            OP_AND, OP_OR, OP_NOR:  state_d.result = logic_w;
            default:                state_d.result = '0;
        endcase
        state_d.ovf  = arith_d && ovf_w && !unsigned_mode;
        state_d.zero = (state_d.result == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    assign result    = state_q.result;
    assign zero_flag = state_q.zero;
    assign ovf_flag  = state_q.ovf;

endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_code,
    input logic         unsigned_mode,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         ovf_flag
);
    a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == 4'b0010) |-> result == $past(opnd_a) + $past(opnd_b));

    a_r2_sub_diff: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == 4'b0110) |-> result == $past(opnd_a) - $past(opnd_b));

    a_r4_slt_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_code) == 4'b0111) |-> result[W-1:1] == '0);

    a_r5_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag == (result == '0));

    a_r7_no_ovf_nonarith: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_code) != 4'b0010 && $past(op_code) != 4'b0110) |-> !ovf_flag);

    a_r8_ovf_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(unsigned_mode) |-> !ovf_flag);

endmodule

bind alu_core alu_core_checker #(.W(alu_pkg::DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_code       (op_code),
    .unsigned_mode (unsigned_mode),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b),
    .result        (result),
    .zero_flag     (zero_flag),
    .ovf_flag      (ovf_flag)
);

// File: tb/alu_core_test.sv
`timescale 1ns/1ps
module alu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic        unsigned_mode = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_core uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .unsigned_mode(unsigned_mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .zero_flag(zero_flag), .ovf_flag(ovf_flag)
    );

    // behavioural reference model
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic uns, output logic [31:0] r, output logic z, output logic o);
        longint sa, sb, s;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        o = 1'b0;
        case (op)
            4'b0010: begin s = sa + sb; r = a + b; o = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            4'b0110: begin s = sa - sb; r = a - b; o = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1100: r = ~(a | b);
            4'b0111: r = (sa < sb) ? 32'd1 : 32'd0;
            default: r = 32'd0;
        endcase
        if (uns) o = 1'b0;
        z = (r == 32'd0);
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'b0010: return "R1";
            4'b0110: return "R2";
            4'b0000, 4'b0001, 4'b1100: return "R3";
            4'b0111: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] er, input logic ez, input logic eo);
        compared++;
        if (result !== er || zero_flag !== ez || ovf_flag !== eo) begin
            mismatched++;
            $display("FAIL %s: got result=%h zero=%b ovf=%b, expected result=%h zero=%b ovf=%b",
                     tag, result, zero_flag, ovf_flag, er, ez, eo);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register on the path, R10)
    task automatic run(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic uns);
        logic [31:0] er; logic ez, eo;
        model(op, a, b, uns, er, ez, eo);
        op_code = op; opnd_a = a; opnd_b = b; unsigned_mode = uns;
        @(negedge clk);
        compare(tag, er, ez, eo);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R10 reset", 32'd0, 1'b1, 1'b0);
        rst_n = 1'b1;

        run("R1 add small", 4'b0010, 32'd5, 32'd7, 1'b0);
        run("R6 add pos overflow", 4'b0010, 32'h7fffffff, 32'd1, 1'b0);
        run("R5 R6 add wraps to zero", 4'b0010, 32'h80000000, 32'h80000000, 1'b0);
        run("R8 add unsigned mode", 4'b0010, 32'h7fffffff, 32'd1, 1'b1);
        run("R2 sub negative", 4'b0110, 32'd3, 32'd5, 1'b0);
        run("R5 sub equal", 4'b0110, 32'd10, 32'd10, 1'b0);
        run("R6 sub neg overflow", 4'b0110, 32'h80000000, 32'd1, 1'b0);
        run("R6 sub pos overflow", 4'b0110, 32'h7fffffff, 32'hffffffff, 1'b0);
        run("R8 sub unsigned mode", 4'b0110, 32'h80000000, 32'd1, 1'b1);
        run("R3 and", 4'b0000, 32'hf0f0_1234, 32'hff00_ff00, 1'b0);
        run("R3 or", 4'b0001, 32'hf0f0_1234, 32'h0f00_00ff, 1'b0);
        run("R3 nor", 4'b1100, 32'h1234_0000, 32'h0000_5678, 1'b0);
        run("R5 nor all ones", 4'b1100, 32'hffffffff, 32'd0, 1'b0);
        run("R4 slt -1<1", 4'b0111, 32'hffffffff, 32'd1, 1'b0);
        run("R4 slt overflow min<1", 4'b0111, 32'h80000000, 32'd1, 1'b0);
        run("R4 slt overflow max>-1", 4'b0111, 32'h7fffffff, 32'hffffffff, 1'b0);
        run("R4 slt equal", 4'b0111, 32'd42, 32'd42, 1'b0);
        run("R7 slt no ovf", 4'b0111, 32'h80000000, 32'h7fffffff, 1'b0);
        run("R7 logic no ovf", 4'b0001, 32'h7fffffff, 32'h7fffffff, 1'b0);
        run("R9 unused 1111", 4'b1111, 32'hdeadbeef, 32'h1, 1'b0);
        run("R9 unused 0011", 4'b0011, 32'h7fffffff, 32'd1, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic [31:0] a, b;
            logic uns;
            op = 4'($urandom_range(0, 15));
            if (i % 2 == 0) begin
                case (i % 6)
                    0: op = 4'b0010;
                    2: op = 4'b0110;
                    default: op = 4'b0111;
                endcase
            end
            a = $urandom;
            b = (i % 10 == 0) ? a : 32'($urandom);
            uns = (i % 7 == 0);
            run(tag_of(op), op, a, b, uns);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                compared++;
                mismatched++;
                $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule